// File: doc/BRIEF.md
# Host-to-Satellite Control Bridge

This block sits between a synchronous host bus and an array of self-timed processing satellites. The lower half of the host address space is a window onto the satellites' configuration memories: a load or store there becomes a configuration read or write strobe, with the address and data passed straight through. Read-back data from the satellites is 16 bits wide and comes back zero-extended on the 32-bit host data bus. The upper half holds a small set of control registers.

Through those registers the host picks which address generators and I/O ports a kernel should launch, fires one-cycle start pulses to them and holds the satellite network in reset when needed. Each acknowledge from a launched unit is synchronised and kept as a sticky status bit. The kernel-done interrupt rises once every launched unit has acknowledged, provided the interrupt mask enables all of them. Software clears status bits by writing ones to them.

A mode bit hands the whole access path to an external test port. While it is set, the test port configures satellites, drives the registers and reads results, and the host bus is ignored. The interrupt output doubles as the end-of-kernel pin for the test equipment.

Top module: `sat_ctrl_bridge`

## Requirements
- R1: An access whose address has bit 15 clear is a configuration access. A write raises cfgWrStb and a read raises cfgRdStb in the same cycle as the select. cfgAddr carries address bits 14:0, and cfgWdata carries the write data. Register accesses raise neither strobe.
- R2: A configuration read returns cfgRdata zero-extended to 32 bits on the read data bus of the active port, in the same cycle.
- R3: Addresses with bit 15 set reach the registers, decoded by address bits 2:0. Offset 0 is control: bit 0 is the test mode, bit 1 is the network reset, and bits 8 and up form a start field that reads back as zero. Offset 1 is the start mask, offset 2 the interrupt mask, offset 3 the sticky status and offset 4 the read-only pending set. All other offsets read zero. Every register resets to zero.
- R4: The netReset output follows control bit 1.
- R5: A control write whose start field ANDed with the start mask is nonzero drives unitStart to that masked value for exactly one cycle, starting after the write's clock edge. The same write loads the pending set with that value and clears those units' status bits.
- R6: A unitAck bit held high for at least two cycles sets its status bit within three clock edges. The bit then stays set until it is cleared.
- R7: Writing the status register clears each bit written as 1 and leaves each bit written as 0. If an acknowledge is present in the same cycle, it wins and the bit stays set.
- R8: kernelIrq is high exactly when three things hold: the pending set is nonzero, every pending unit has its status bit set, and every pending unit is enabled in the interrupt mask.
- R9: While test mode is 0, the host port drives all accesses and the test port is ignored, with its read data at zero. While test mode is 1, the roles swap.
- R10: A control write whose masked start field is zero produces no start pulse and leaves the pending set and the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access valid |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostAddr | input | 16 | Host address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data |
| testSel | input | 1 | Test port access valid |
| testWe | input | 1 | Test port write (1) or read (0) |
| testAddr | input | 16 | Test port address |
| testWdata | input | 32 | Test port write data |
| testRdata | output | 32 | Test port read data |
| cfgAddr | output | 15 | Configuration memory address to satellites |
| cfgWdata | output | 32 | Configuration write data |
| cfgWrStb | output | 1 | Configuration write strobe |
| cfgRdStb | output | 1 | Configuration read strobe |
| cfgRdata | input | 16 | Configuration read-back data from satellites |
| netReset | output | 1 | Satellite network reset level |
| unitStart | output | 6 | One-cycle start requests to address generators and I/O ports |
| unitAck | input | 6 | Acknowledges from address generators and I/O ports |
| kernelIrq | output | 1 | End-of-kernel interrupt |

## Verification
The bench checks that a start pulse is filtered by the start mask and lasts one cycle. A design that leaked masked units or held the pulse would launch satellites twice or launch the wrong ones. It checks that the interrupt waits for the last pending acknowledge, ignores acknowledges from units outside the pending set, and falls when an interrupt mask bit is removed. It checks that an acknowledge arriving during a write-one-to-clear survives, and that a zero masked start does not disturb the pending state, which would otherwise lose a completion. Finally, it checks that host traffic in test mode, and test-port traffic in host mode, produce no strobes and change no register.

// File: rtl/sat_bridge_pkg.sv
package sat_bridge_pkg;

  // Register offsets inside the register half of the address space
  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_SMASK  = 3'd1;
  localparam logic [2:0] REG_IMASK  = 3'd2;
  localparam logic [2:0] REG_STATUS = 3'd3;
  localparam logic [2:0] REG_PEND   = 3'd4;

  // Control bit positions
  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_NRST_BIT = 1;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic cfgWr;
    logic cfgRd;
    logic regRd;
  } acc_strobe_t;

endpackage

// File: rtl/sat_bridge_ctrl.sv
module sat_bridge_ctrl
  import sat_bridge_pkg::*;
#(
  parameter int NUM_UNITS   = 6,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int START_LSB   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accSel,
  input  logic                 accWe,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic [DATA_W-1:0]    accWdata,
  input  logic [NUM_UNITS-1:0] unitAck,
  output acc_strobe_t          strb,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 testMode,
  output logic                 netReset,
  output logic [NUM_UNITS-1:0] unitStart,
  output logic                 kernelIrq
);

  localparam int REG_SPACE_BIT = ADDR_W - 1;

  logic                 isReg;
  logic [2:0]           regIdx;
  logic                 regWr;
  logic                 ctrlWr;
  logic                 smaskWr;
  logic                 imaskWr;
  logic                 statClr;
  logic [NUM_UNITS-1:0] startReq;
  logic                 startEv;

  logic [NUM_UNITS-1:0] startMask;
  logic [NUM_UNITS-1:0] irqMask;
  logic [NUM_UNITS-1:0] status;
  logic [NUM_UNITS-1:0] statusNxt;
  logic [NUM_UNITS-1:0] pending;
  logic [NUM_UNITS-1:0] ackSeen;
  logic [NUM_UNITS-1:0] syncQ [SYNC_STAGES];

  // Address decode
  assign isReg    = accAddr[REG_SPACE_BIT];
  assign regIdx   = accAddr[2:0];
  assign regWr    = accSel & accWe & isReg;
  assign ctrlWr   = regWr && (regIdx == REG_CTRL);
  assign smaskWr  = regWr && (regIdx == REG_SMASK);
  assign imaskWr  = regWr && (regIdx == REG_IMASK);
  assign statClr  = regWr && (regIdx == REG_STATUS);
  assign startReq = accWdata[START_LSB +: NUM_UNITS] & startMask;
  assign startEv  = ctrlWr && (|startReq);

  always_comb begin
    strb.cfgWr = accSel & accWe & ~isReg;
    strb.cfgRd = accSel & ~accWe & ~isReg;
    strb.regRd = accSel & ~accWe & isReg;
  end

  // Control and mask registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      testMode  <= 1'b0;
      netReset  <= 1'b0;
      startMask <= '0;
      irqMask   <= '0;
    end else begin
      if (ctrlWr) begin
        testMode <= accWdata[CTRL_MODE_BIT];
        netReset <= accWdata[CTRL_NRST_BIT];
      end
      if (smaskWr) startMask <= accWdata[NUM_UNITS-1:0];
      if (imaskWr) irqMask   <= accWdata[NUM_UNITS-1:0];
    end
  end

  // Acknowledge synchroniser chain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= unitAck;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign ackSeen = syncQ[SYNC_STAGES-1];

  // Sticky status: launch and write-one clear first, acknowledge wins
  always_comb begin
    statusNxt = status;
    if (startEv) statusNxt = statusNxt & ~startReq;
    if (statClr) statusNxt = statusNxt & ~accWdata[NUM_UNITS-1:0];
    statusNxt = statusNxt | ackSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status    <= '0;
      pending   <= '0;
      unitStart <= '0;
    end else begin
      status    <= statusNxt;
      unitStart <= startEv ? startReq : '0;
      if (startEv) pending <= startReq;
    end
  end

  // Kernel completion
  always_comb begin
    kernelIrq = (|pending) && ((pending & ~status) == '0) && ((pending & ~irqMask) == '0);
  end

  // Register read mux
  always_comb begin
    regRdata = '0;
    unique case (regIdx)
      REG_CTRL: begin
        regRdata[CTRL_MODE_BIT] = testMode;
        regRdata[CTRL_NRST_BIT] = netReset;
      end
      REG_SMASK:  regRdata[NUM_UNITS-1:0] = startMask;
      REG_IMASK:  regRdata[NUM_UNITS-1:0] = irqMask;
      REG_STATUS: regRdata[NUM_UNITS-1:0] = status;
      REG_PEND:   regRdata[NUM_UNITS-1:0] = pending;
      default:    regRdata = '0;
    endcase
  end

  AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|unitStart) |-> $past(ctrlWr)); // R5
  AST_START_IN_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (|unitStart) |-> ((unitStart & ~startMask) == '0)); // R5
  AST_NO_IRQ_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (|unitStart) |-> !kernelIrq); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!statClr && !startEv) |=> (($past(status) & ~status) == '0)); // R6

endmodule

// File: rtl/sat_bridge_dp.sv
module sat_bridge_dp
  import sat_bridge_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int RD_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              testSel,
  input  logic              testWe,
  input  logic [ADDR_W-1:0] testAddr,
  input  logic [DATA_W-1:0] testWdata,
  output logic [DATA_W-1:0] testRdata,
  output logic              accSel,
  output logic              accWe,
  output logic [ADDR_W-1:0] accAddr,
  output logic [DATA_W-1:0] accWdata,
  input  acc_strobe_t       strb,
  input  logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-2:0] cfgAddr,
  output logic [DATA_W-1:0] cfgWdata,
  output logic              cfgWrStb,
  output logic              cfgRdStb,
  input  logic [RD_W-1:0]   cfgRdata
);

  logic [DATA_W-1:0] rdMux;

  // Port steering by mode
  always_comb begin
    if (testMode) begin
      accSel   = testSel;
      accWe    = testWe;
      accAddr  = testAddr;
      accWdata = testWdata;
    end else begin
      accSel   = hostSel;
      accWe    = hostWe;
      accAddr  = hostAddr;
      accWdata = hostWdata;
    end
  end

  assign cfgAddr  = accAddr[ADDR_W-2:0];
  assign cfgWdata = accWdata;
  assign cfgWrStb = strb.cfgWr;
  assign cfgRdStb = strb.cfgRd;

  always_comb begin
    rdMux = '0;
    if (strb.cfgRd)      rdMux = {{(DATA_W-RD_W){1'b0}}, cfgRdata};
    else if (strb.regRd) rdMux = regRdata;
  end

  assign hostRdata = testMode ? '0 : rdMux;
  assign testRdata = testMode ? rdMux : '0;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrStb && cfgRdStb)); // R1
  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !testSel) |-> (!cfgWrStb && !cfgRdStb && hostRdata == '0)); // R9
  AST_TEST_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode && !hostSel) |-> (!cfgWrStb && !cfgRdStb && testRdata == '0)); // R9

endmodule

// File: rtl/sat_ctrl_bridge.sv
module sat_ctrl_bridge
  import sat_bridge_pkg::*;
#(
  parameter int NUM_UNITS   = 6,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int RD_W        = 16,
  parameter int START_LSB   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostSel,
  input  logic                 hostWe,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostWdata,
  output logic [DATA_W-1:0]    hostRdata,
  input  logic                 testSel,
  input  logic                 testWe,
  input  logic [ADDR_W-1:0]    testAddr,
  input  logic [DATA_W-1:0]    testWdata,
  output logic [DATA_W-1:0]    testRdata,
  output logic [ADDR_W-2:0]    cfgAddr,
  output logic [DATA_W-1:0]    cfgWdata,
  output logic                 cfgWrStb,
  output logic                 cfgRdStb,
  input  logic [RD_W-1:0]      cfgRdata,
  output logic                 netReset,
  output logic [NUM_UNITS-1:0] unitStart,
  input  logic [NUM_UNITS-1:0] unitAck,
  output logic                 kernelIrq
);

  logic              testMode;
  logic              accSel;
  logic              accWe;
  logic [ADDR_W-1:0] accAddr;
  logic [DATA_W-1:0] accWdata;
  logic [DATA_W-1:0] regRdata;
  acc_strobe_t       strb;

  sat_bridge_ctrl #(
    .NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .START_LSB(START_LSB), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .accSel(accSel), .accWe(accWe), .accAddr(accAddr), .accWdata(accWdata),
    .unitAck(unitAck), .strb(strb), .regRdata(regRdata),
    .testMode(testMode), .netReset(netReset),
    .unitStart(unitStart), .kernelIrq(kernelIrq)
  );

  sat_bridge_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_W(RD_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .testMode(testMode),
    .hostSel(hostSel), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .testSel(testSel), .testWe(testWe), .testAddr(testAddr),
    .testWdata(testWdata), .testRdata(testRdata),
    .accSel(accSel), .accWe(accWe), .accAddr(accAddr), .accWdata(accWdata),
    .strb(strb), .regRdata(regRdata),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgWrStb(cfgWrStb), .cfgRdStb(cfgRdStb), .cfgRdata(cfgRdata)
  );

endmodule

// File: tb/sim_sat_ctrl_bridge.sv
module sim_sat_ctrl_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWe = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        testSel = 1'b0, testWe = 1'b0;
  logic [15:0] testAddr = '0;
  logic [31:0] testWdata = '0;
  logic [31:0] testRdata;
  logic [14:0] cfgAddr;
  logic [31:0] cfgWdata;
  logic        cfgWrStb, cfgRdStb;
  logic [15:0] cfgRdata;
  logic        netReset;
  logic [5:0]  unitStart;
  logic [5:0]  unitAck = '0;
  logic        kernelIrq;

  int checks = 0;
  int failures = 0;

  // Satellite read-back model
  assign cfgRdata = {1'b0, cfgAddr} ^ 16'h5A5A;

  always #2.5 clk = ~clk;

  sat_ctrl_bridge u0 (
    .clk(clk), .rstN(rstN),
    .hostSel(hostSel), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .testSel(testSel), .testWe(testWe), .testAddr(testAddr),
    .testWdata(testWdata), .testRdata(testRdata),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgWrStb(cfgWrStb), .cfgRdStb(cfgRdStb), .cfgRdata(cfgRdata),
    .netReset(netReset), .unitStart(unitStart),
    .unitAck(unitAck), .kernelIrq(kernelIrq)
  );

  typedef struct packed {
    logic        we;
    logic [15:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic        eWr;
    logic        eRd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{1'b1, 16'h0123, 32'hA5A5_0001, 32'h0,        1'b1, 1'b0},
    '{1'b0, 16'h7FFF, 32'h0,         32'h0000_25A5, 1'b0, 1'b1},
    '{1'b1, 16'h8001, 32'h0000_003F, 32'h0,        1'b0, 1'b0},
    '{1'b0, 16'h8001, 32'h0,         32'h0000_003F, 1'b0, 1'b0},
    '{1'b1, 16'h8002, 32'h0000_0015, 32'h0,        1'b0, 1'b0},
    '{1'b0, 16'h8002, 32'h0,         32'h0000_0015, 1'b0, 1'b0},
    '{1'b0, 16'h8003, 32'h0,         32'h0,        1'b0, 1'b0},
    '{1'b0, 16'h8005, 32'h0,         32'h0,        1'b0, 1'b0},
    '{1'b1, 16'h8000, 32'h0000_0002, 32'h0,        1'b0, 1'b0},
    '{1'b0, 16'h8000, 32'h0,         32'h0000_0002, 1'b0, 1'b0},
    '{1'b1, 16'h8000, 32'h0,         32'h0,        1'b0, 1'b0},
    '{1'b0, 16'h0000, 32'h0,         32'h0000_5A5A, 1'b0, 1'b1}
  };

  logic [31:0] rdH, rdT, sWd;
  logic        sWr, sRd;
  logic [14:0] sAddr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access on host (port=0) or test (port=1); commits at the posedge
  task automatic acc(input bit port, input bit we, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    if (port) begin
      testSel = 1'b1; testWe = we; testAddr = a; testWdata = d;
    end else begin
      hostSel = 1'b1; hostWe = we; hostAddr = a; hostWdata = d;
    end
    #1;
    rdH = hostRdata; rdT = testRdata; sWr = cfgWrStb; sRd = cfgRdStb;
    sAddr = cfgAddr; sWd = cfgWdata;
    @(posedge clk);
    #0.5;
    hostSel = 1'b0; testSel = 1'b0; hostWe = 1'b0; testWe = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setAck(input logic [5:0] v);
    @(negedge clk);
    unitAck = v;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // Reset state R3
    chk("R3 reset unitStart", {26'd0, unitStart}, 32'h0);
    chk("R3 reset irq", {31'd0, kernelIrq}, 32'h0);
    chk("R4 reset netReset", {31'd0, netReset}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    acc(0, 0, 16'h8000, 0);
    chk("R3 reset ctrl read", rdH, 32'h0);
    acc(0, 0, 16'h8004, 0);
    chk("R3 reset pending read", rdH, 32'h0);

    // Vector table: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      acc(0, VT[i].we, VT[i].a, VT[i].d);
      chk($sformatf("R1 vec%0d cfgWrStb", i), {31'd0, sWr}, {31'd0, VT[i].eWr});
      chk($sformatf("R1 vec%0d cfgRdStb", i), {31'd0, sRd}, {31'd0, VT[i].eRd});
      if (VT[i].eWr || VT[i].eRd)
        chk($sformatf("R1 vec%0d cfgAddr", i), {17'd0, sAddr}, {17'd0, VT[i].a[14:0]});
      if (VT[i].eWr)
        chk($sformatf("R1 vec%0d cfgWdata", i), sWd, VT[i].d);
      if (!VT[i].we)
        chk($sformatf("R2 R3 vec%0d rdata", i), rdH, VT[i].exp);
      if (VT[i].a == 16'h8000 && VT[i].we)
        chk($sformatf("R4 vec%0d netReset", i), {31'd0, netReset}, {31'd0, VT[i].d[1]});
    end

    // Launch with mask R5
    acc(0, 1, 16'h8001, 32'h0F);
    acc(0, 1, 16'h8002, 32'h3F);
    acc(0, 1, 16'h8000, 32'h3300);
    chk("R5 start pulse", {26'd0, unitStart}, 32'h03);
    waitEdges(1);
    chk("R5 start single cycle", {26'd0, unitStart}, 32'h0);
    acc(0, 0, 16'h8004, 0);
    chk("R5 pending", rdH, 32'h03);
    chk("R8 irq idle", {31'd0, kernelIrq}, 32'h0);

    // Acknowledges R6 R8
    setAck(6'h01); waitEdges(4);
    acc(0, 0, 16'h8003, 0);
    chk("R6 status one ack", rdH, 32'h01);
    chk("R8 irq partial", {31'd0, kernelIrq}, 32'h0);
    setAck(6'h03); waitEdges(4);
    chk("R8 irq all acked", {31'd0, kernelIrq}, 32'h1);
    setAck(6'h23); waitEdges(4);
    setAck(6'h00); waitEdges(4);
    acc(0, 0, 16'h8003, 0);
    chk("R6 status sticky", rdH, 32'h23);
    chk("R8 irq extra ack", {31'd0, kernelIrq}, 32'h1);

    // Write-one clear R7
    acc(0, 1, 16'h8003, 32'h01);
    acc(0, 0, 16'h8003, 0);
    chk("R7 w1c", rdH, 32'h22);
    chk("R8 irq after clear", {31'd0, kernelIrq}, 32'h0);
    acc(0, 1, 16'h8003, 32'h00);
    acc(0, 0, 16'h8003, 0);
    chk("R7 write zero", rdH, 32'h22);

    // Zero masked start R10
    acc(0, 1, 16'h8000, 32'h3000);
    chk("R10 no pulse", {26'd0, unitStart}, 32'h0);
    acc(0, 0, 16'h8004, 0);
    chk("R10 pending kept", rdH, 32'h03);
    acc(0, 0, 16'h8003, 0);
    chk("R10 status kept", rdH, 32'h22);

    // Interrupt mask R8
    setAck(6'h01); waitEdges(4);
    setAck(6'h00); waitEdges(4);
    chk("R8 irq restored", {31'd0, kernelIrq}, 32'h1);
    acc(0, 1, 16'h8002, 32'h3E);
    chk("R8 irq masked", {31'd0, kernelIrq}, 32'h0);
    acc(0, 1, 16'h8002, 32'h3F);
    chk("R8 irq unmasked", {31'd0, kernelIrq}, 32'h1);

    // Relaunch clears launched status R5
    acc(0, 1, 16'h8000, 32'h0100);
    chk("R5 relaunch pulse", {26'd0, unitStart}, 32'h01);
    chk("R5 relaunch irq low", {31'd0, kernelIrq}, 32'h0);
    acc(0, 0, 16'h8003, 0);
    chk("R5 relaunch status", rdH, 32'h22);

    // Ack beats clear R7
    setAck(6'h04); waitEdges(4);
    acc(0, 1, 16'h8003, 32'h04);
    acc(0, 0, 16'h8003, 0);
    chk("R7 ack wins", rdH, 32'h26);
    setAck(6'h00); waitEdges(4);
    acc(0, 1, 16'h8003, 32'h04);
    acc(0, 0, 16'h8003, 0);
    chk("R7 clear after ack gone", rdH, 32'h22);

    // Test mode R9 R2
    acc(0, 1, 16'h8000, 32'h1);
    acc(0, 1, 16'h0010, 32'h1234);
    chk("R9 host write ignored", {31'd0, sWr}, 32'h0);
    acc(0, 0, 16'h8003, 0);
    chk("R9 host read zero", rdH, 32'h0);
    acc(1, 1, 16'h0456, 32'hDEAD_BEEF);
    chk("R9 test cfg strobe", {31'd0, sWr}, 32'h1);
    chk("R9 test cfgAddr", {17'd0, sAddr}, 32'h0456);
    chk("R9 test cfgWdata", sWd, 32'hDEAD_BEEF);
    acc(1, 0, 16'h0002, 0);
    chk("R2 test read", rdT, 32'h0000_5A58);
    acc(0, 1, 16'h8000, 32'h0);
    acc(1, 0, 16'h8000, 0);
    chk("R9 host ctrl write ignored", rdT, 32'h1);
    acc(1, 1, 16'h8000, 32'h0);
    acc(1, 1, 16'h0020, 32'h55);
    chk("R9 test write ignored", {31'd0, sWr}, 32'h0);
    acc(1, 0, 16'h8003, 0);
    chk("R9 test read zero", rdT, 32'h0);
    acc(0, 0, 16'h8003, 0);
    chk("R9 host owns again", rdH, 32'h22);

    summary();
  end

endmodule